// File: doc/BRIEF.md
# Rotate-Left Execution Unit

This unit carries out a rotate-left of an 8-, 16- or 32-bit operand the way an older 16/32-bit processor core does, and spends the same number of clock cycles that such a core would. A caller presents the operand, a size code, and a rotate count, then pulses `start`. The count comes from a 3-bit immediate field or from the low six bits of a count register. A separate memory form rotates a 16-bit word by exactly one place. When the cycle budget is spent, the unit raises `done` for one cycle. The result and the N, Z, V, C and X flags are then valid, and they stay valid until the next accepted start.

The control is a three-state machine. **IDLE** waits for `start`. The transition *accept* (IDLE to COUNT) latches the result and flags and loads the cycle timer. **COUNT** runs the timer down. It takes the transition *tick* (COUNT to COUNT) while the timer is nonzero and *expire* (COUNT to FINISH) when it reaches zero. **FINISH** drives `done` and takes *release* (FINISH to IDLE) on the next edge. Bits above the selected width pass through untouched.

Top module: `rotl_exec_unit`

## Requirements
- R1: Size code 2'b00 rotates bits [7:0], 2'b01 rotates bits [15:0], and 2'b10 rotates all 32 bits. For byte and word sizes, operand bits above the selected width appear unchanged in the result.
- R2: With `count_src`=0 the rotate count is `imm_cnt`, and a field value of 0 means 8. With `count_src`=1 the count is `reg_cnt`, the count register's low six bits, so a count register of 200 rotates by 8.
- R3: V is always 0. C equals bit 0 of the result when the rotate count is nonzero, and is 0 when the count is 0.
- R4: N is the top bit of the result at the selected width. Z is 1 exactly when the result at that width is zero.
- R5: X equals the value of `x_in` sampled with the accepted start. The rotate never alters it.
- R6: With rotate count n, an operation takes 6+2n cycles for byte and word sizes and 8+2n cycles for long. For example, a long rotate by 3 takes 14 cycles and a word rotate by 36 takes 78.
- R7: With `mem_form`=1, bits [15:0] rotate left by exactly one place and the operation takes 16 cycles, whatever `size`, `count_src` and the counts hold. For example, 0xd567 becomes 0xaacf with N and C set.
- R8: If `start` is sampled at rising edge e and the operation takes T cycles, `done` is high for exactly the one cycle that follows edge e+T-1. The result and flags do not change from the edge after e until the next accepted start.
- R9: A `start` raised while `busy` is high is ignored. The running operation's result and timing are unaffected.
- R10: While `rst_n` is low at a rising edge, the unit returns to IDLE and clears `done`, `busy`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only in IDLE) |
| operand | input | 32 | Value to rotate |
| size | input | 2 | 00 byte, 01 word, 10 long |
| count_src | input | 1 | 0 immediate count, 1 register count |
| imm_cnt | input | 3 | Immediate count field (0 means 8) |
| reg_cnt | input | 6 | Low six bits of the count register |
| mem_form | input | 1 | Memory form: word rotate by one |
| x_in | input | 1 | Current extend flag |
| result | output | 32 | Rotated value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes that `size` never carries 2'b11 at an accepted start; it records the width from the size code in that cycle and checks N and Z against it. The flag assertions also rely on operation inputs mattering only in the start cycle. Because of that, the bench may change them freely afterwards, and the ignored-start test relies on this. The stimulus drives inputs only on falling edges, uses only the three defined size codes, and holds `start` for a single cycle.

// File: rtl/rotl_pkg.sv
package rotl_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FINISH
    } state_e;

endpackage

// File: rtl/rotl_barrel.sv
module rotl_barrel #(
    parameter int W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    dout
);

    logic [W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = sh[s] ? {stage[s][W-1-D:0], stage[s][W-1 -: D]}
                                  : stage[s];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/rotl_cycle_calc.sv
module rotl_cycle_calc #(
    parameter int CNT_W       = 6,
    parameter int TMR_W       = 8,
    parameter int BASE_CYC    = 6,
    parameter int PER_BIT_CYC = 2,
    parameter int LONG_EXTRA  = 2,
    parameter int MEM_CYC     = 16
) (
    input  logic             is_long,
    input  logic             is_mem,
    input  logic [CNT_W-1:0] count,
    output logic [TMR_W-1:0] total
);

    logic [TMR_W-1:0] scaled;

    always_comb begin
        scaled = TMR_W'(PER_BIT_CYC) * TMR_W'(count);
        if (is_mem) begin
            total = TMR_W'(MEM_CYC);
        end else begin
            total = TMR_W'(BASE_CYC) + scaled
                  + (is_long ? TMR_W'(LONG_EXTRA) : '0);
        end
    end

endmodule

// File: rtl/rotl_exec_unit.sv
module rotl_exec_unit
    import rotl_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int BASE_CYC    = 6,
    parameter int PER_BIT_CYC = 2,
    parameter int LONG_EXTRA  = 2,
    parameter int MEM_CYC     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        size,
    input  logic              count_src,
    input  logic [2:0]        imm_cnt,
    input  logic [CNT_W-1:0]  reg_cnt,
    input  logic              mem_form,
    input  logic              x_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              flag_x,
    output logic              busy,
    output logic              done
);

    localparam int MAX_CYC = BASE_CYC + LONG_EXTRA + PER_BIT_CYC * ((1 << CNT_W) - 1);
    localparam int TMR_W   = $clog2((MAX_CYC > MEM_CYC ? MAX_CYC : MEM_CYC) + 1);

    state_e           state, state_nx;
    logic [TMR_W-1:0] timer;
    logic [TMR_W-1:0] cyc_total;
    logic [CNT_W-1:0] n_raw;
    logic [1:0]       sel_w;
    logic [DATA_W-1:0] rot_full [NUM_SIZES];
    logic [DATA_W-1:0] res_nx;
    logic             n_nx, z_nx, c_nx;
    logic             start_ok;

    assign start_ok = start && (state == ST_IDLE);

    // Rotate count and width selection
    always_comb begin
        if (mem_form) begin
            n_raw = CNT_W'(1);
        end else if (count_src) begin
            n_raw = reg_cnt;
        end else if (imm_cnt == 3'd0) begin
            n_raw = CNT_W'(8);
        end else begin
            n_raw = CNT_W'(imm_cnt);
        end

        if (mem_form) begin
            sel_w = 2'd1;
        end else begin
            unique case (size)
                SZ_BYTE: sel_w = 2'd0;
                SZ_WORD: sel_w = 2'd1;
                default: sel_w = 2'd2;
            endcase
        end
    end

    // One rotator per operand width
    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_width
        localparam int W  = 8 << gi;
        localparam int SW = $clog2(W);
        logic [W-1:0] part;

        rotl_barrel #(.W(W)) u_rot (
            .din  (operand[W-1:0]),
            .sh   (n_raw[SW-1:0]),
            .dout (part)
        );

        if (W == DATA_W) begin : g_full
            assign rot_full[gi] = part;
        end else begin : g_part
            assign rot_full[gi] = {operand[DATA_W-1:W], part};
        end
    end

    // Result and flag selection
    always_comb begin
        unique case (sel_w)
            2'd0: begin
                res_nx = rot_full[0];
                n_nx   = res_nx[7];
                z_nx   = (res_nx[7:0] == '0);
            end
            2'd1: begin
                res_nx = rot_full[1];
                n_nx   = res_nx[15];
                z_nx   = (res_nx[15:0] == '0);
            end
            default: begin
                res_nx = rot_full[2];
                n_nx   = res_nx[DATA_W-1];
                z_nx   = (res_nx == '0);
            end
        endcase
        c_nx = (n_raw != '0) && res_nx[0];
    end

    rotl_cycle_calc #(
        .CNT_W      (CNT_W),
        .TMR_W      (TMR_W),
        .BASE_CYC   (BASE_CYC),
        .PER_BIT_CYC(PER_BIT_CYC),
        .LONG_EXTRA (LONG_EXTRA),
        .MEM_CYC    (MEM_CYC)
    ) u_cyc (
        .is_long (sel_w == 2'd2),
        .is_mem  (mem_form),
        .count   (n_raw),
        .total   (cyc_total)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_COUNT;         // accept
            ST_COUNT:  if (timer == '0) state_nx = ST_FINISH;  // expire / tick
            ST_FINISH: state_nx = ST_IDLE;                     // release
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and cycle timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            timer <= '0;
        end else begin
            state <= state_nx;
            if (start_ok) begin
                timer <= cyc_total - TMR_W'(2);
            end else if (state == ST_COUNT && timer != '0) begin
                timer <= timer - TMR_W'(1);
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end

    // Result and flags, captured on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
            flag_x <= 1'b0;
        end else if (start_ok) begin
            result <= res_nx;
            flag_n <= n_nx;
            flag_z <= z_nx;
            flag_v <= 1'b0;
            flag_c <= c_nx;
            flag_x <= x_in;
        end
    end

endmodule

// File: rtl/rotl_exec_unit_chk.sv
module rotl_exec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mem_form,
    input logic [1:0]  size,
    input logic [31:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c,
    input logic        busy,
    input logic        done
);

    logic [1:0] w_q;
    logic [7:0] busy_cyc;
    logic       top_bit;
    logic       is_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q      <= 2'd2;
            busy_cyc <= '0;
        end else if (start && !busy) begin
            w_q      <= mem_form ? 2'd1 : (size == 2'b00 ? 2'd0 : (size == 2'b01 ? 2'd1 : 2'd2));
            busy_cyc <= '0;
        end else if (busy && busy_cyc != 8'hff) begin
            busy_cyc <= busy_cyc + 8'd1;
        end
    end

    always_comb begin
        case (w_q)
            2'd0:    begin top_bit = result[7];  is_zero = (result[7:0] == '0);  end
            2'd1:    begin top_bit = result[15]; is_zero = (result[15:0] == '0); end
            default: begin top_bit = result[31]; is_zero = (result == '0);       end
        endcase
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_v);

    a_r3_carry_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_c) |-> result[0]);

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == is_zero));

    a_r4_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_n == top_bit));

    a_r6_min_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cyc >= 8'd5));

endmodule

bind rotl_exec_unit rotl_exec_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_form (mem_form),
    .size     (size),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .busy     (busy),
    .done     (done)
);

// File: tb/rotl_exec_unit_test.sv
`timescale 1ns/1ps
module rotl_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size = 2'b00;
    logic        count_src = 1'b0;
    logic [2:0]  imm_cnt = '0;
    logic [5:0]  reg_cnt = '0;
    logic        mem_form = 1'b0;
    logic        x_in = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rotl_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .size(size),
        .count_src(count_src), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .mem_form(mem_form), .x_in(x_in), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .flag_x(flag_x), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One operation: drive, measure cycles, compare against arithmetic model
    task automatic run_op(input logic [31:0] op, input logic [1:0] sz, input bit src,
                          input int imm, input int rc, input bit mem, input bit x,
                          input bit poke_busy);
        int w, n, r, t_exp, k;
        longint unsigned mask, v, rv, res_e;
        bit n_e, z_e, c_e, seen;
        w = mem ? 16 : (sz == 2'b00 ? 8 : (sz == 2'b01 ? 16 : 32));
        n = mem ? 1 : (src ? (rc % 64) : (imm == 0 ? 8 : imm));
        r = n % w;
        mask = (64'd1 << w) - 1;
        v = {32'd0, op} & mask;
        rv = (r == 0) ? v : (((v << r) | (v >> (w - r))) & mask);
        res_e = ({32'd0, op} & ~mask & 64'hffff_ffff) | rv;
        n_e = rv[w-1];
        z_e = (rv == 0);
        c_e = (n != 0) && rv[0];
        t_exp = mem ? 16 : (6 + 2 * n + (w == 32 ? 2 : 0));

        @(negedge clk);
        operand = op; size = sz; count_src = src; imm_cnt = 3'(imm);
        reg_cnt = 6'(rc); mem_form = mem; x_in = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        seen = 0;
        while (k < 300) begin
            @(negedge clk);
            k++;
            if (poke_busy && k == 2) begin
                operand = ~op; size = 2'b10; imm_cnt = 3'd5; reg_cnt = 6'd3;
                mem_form = 1'b0; count_src = ~src; x_in = ~x; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin seen = 1; break; end
        end
        start = 1'b0;
        chk(seen, "R8", "done seen", longint'(seen), 1);
        if (seen) begin
            if (mem) chk(k + 1 == t_exp, "R7", "mem cycles", k + 1, t_exp);
            else chk(k + 1 == t_exp, "R6", "cycles", k + 1, t_exp);
            if (poke_busy) chk(k + 1 == t_exp, "R9", "timing with start while busy", k + 1, t_exp);
            if (mem) chk(result == res_e[31:0], "R7", "mem result", result, res_e);
            else if (src) chk(result == res_e[31:0], "R2", "result reg count", result, res_e);
            else chk(result == res_e[31:0], "R1", "result", result, res_e);
            if (poke_busy) chk(result == res_e[31:0], "R9", "result with start while busy", result, res_e);
            chk({flag_v, flag_c} == {1'b0, c_e}, "R3", "V,C", {flag_v, flag_c}, {1'b0, c_e});
            chk({flag_n, flag_z} == {n_e, z_e}, "R4", "N,Z", {flag_n, flag_z}, {n_e, z_e});
            chk(flag_x == x, "R5", "X", flag_x, x);
            @(negedge clk);
            chk(!done && !busy, "R8", "single done pulse", {done, busy}, 0);
            chk(result == res_e[31:0], "R8", "result held", result, res_e);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ops [3];
        ops[0] = 32'hce3dd567; ops[1] = 32'h80000001; ops[2] = 32'h00000000;

        repeat (3) @(negedge clk);
        chk({done, busy, result, flag_n, flag_z, flag_v, flag_c, flag_x} == '0,
            "R10", "reset state", {done, busy, result}, 0);
        rst_n = 1'b1;

        // Known points (R6, R2, R3)
        run_op(32'hce3dd567, 2'b10, 0, 3, 0, 0, 1, 0);   // 14 cycles
        run_op(32'hce3dd567, 2'b01, 1, 0, 20, 0, 1, 0);  // 46 cycles
        run_op(32'hce3dd567, 2'b01, 1, 0, 36, 0, 0, 0);  // 78 cycles
        run_op(32'hce3dd567, 2'b01, 1, 0, 0, 0, 1, 0);   // zero count, C clear
        run_op(32'hce3dd567, 2'b10, 1, 0, 200 % 64, 0, 0, 0); // R2 count 200
        chk(result == 32'h3dd567ce, "R2", "count 200 long", result, 32'h3dd567ce);

        // Immediate sweep (R1, R2)
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 8; i++)
                for (int o = 0; o < 3; o++)
                    run_op(ops[o], 2'(s), 0, i, 0, 0, 1'((i + o) & 1), 0);

        // Register-count sweep past 64 (R2, R3, R6)
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 71; c++)
                for (int o = 0; o < 2; o++)
                    run_op(ops[o], 2'(s), 1, 0, c, 0, 1'(c & 1), 0);

        // Memory form (R7)
        run_op(32'h0000d567, 2'b10, 1, 0, 9, 1, 1, 0);
        chk(result[15:0] == 16'haacf, "R7", "d567 rotate", result, 32'haacf);
        run_op(32'h00000000, 2'b00, 0, 3, 0, 1, 0, 0);
        run_op(32'h12348000, 2'b10, 0, 7, 0, 1, 1, 0);

        // Start while busy (R9)
        run_op(32'hce3dd567, 2'b10, 1, 0, 10, 0, 0, 1);
        run_op(32'h000000a5, 2'b00, 0, 2, 0, 0, 1, 1);

        // Reset mid-operation (R10)
        @(negedge clk);
        operand = 32'hffffffff; size = 2'b10; count_src = 1; reg_cnt = 6'd4; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk({done, busy, result, flag_n, flag_c} == '0, "R10", "reset mid-run",
            {done, busy, result}, 0);
        rst_n = 1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule